// File: doc/BRIEF.md
# Exception Entry State Generator

This block works out the architectural state a processor core loads when it takes an exception, and the state it restores when it returns from one. When `take_i` is sampled high, the block reads several inputs together: the current machine-state word, the current program counter, the exception code, a power-save flag, the translation-offset mode, the vector prefix and a table holding one handler address for each exception code. From these it registers the saved program counter, the saved status word, the new machine-state word and the handler address, and it pulses `taken_o`. It can also signal a fault instead: it pulses `err_o` when the handler vector is undefined or the combination of inputs is unsupported, and it enters a latched checkstop when a machine check arrives while machine checks are disabled.

A core that was asleep in power-save passes through this block on wake-up. The exception that woke it is redirected to the reset handler, and a cause code records in the saved status what the real reason was. When `ret_i` is sampled high, the block rebuilds the program counter and the machine state from its own save registers.

The control has two states. The normal state is IDLE. The sticky state is CHECKSTOP. The transition IDLE→CHECKSTOP fires on a take of a machine check while machine checks are disabled. CHECKSTOP→CHECKSTOP holds until reset. IDLE→IDLE covers a normal take, an error, a return and idle cycles. Reset returns the block to IDLE.

Top module: `ex_entry_gen`

## Requirements
- R1: On a take, the saved program counter equals the `cur_pc_i` that was sampled. The saved status equals `cur_st_i` with the bits of mask 0x783F0000 cleared. When `emb_model_i` is 1, the saved status is `cur_st_i` unchanged.
- R2: The new machine state keeps only bit 12 (machine-check enable) and bit 60 (hypervisor) of `cur_st_i`. All other bits are zero for ordinary codes: external=2, decrementer=3, doorbell=4, program=7 and syscall=8.
- R3: A machine check (code 1) clears bit 12 and sets bit 60 in the new state. If bit 12 of `cur_st_i` is 0, the block enters CHECKSTOP: `chkstop_o` rises one cycle later and stays high until reset, and no later take or return changes any output.
- R4: Hypervisor-class codes set bit 60 in the new state and copy bit 1 (recoverable) from `cur_st_i`. These codes are hypervisor doorbell=5, hypervisor maintenance=6 and hypervisor decrementer=9.
- R5: With `psave_i`=1 and a code other than 1, the handler comes from table entry 0 (reset). The saved status gets bit 16 set and a wake cause in bits 21:18: reset 0x4, external 0x8, decrementer 0x6, doorbell 0x5, hypervisor doorbell 0x3, hypervisor maintenance 0xA. On a wake, the new state has bits 12 and 60 set. A machine check in power-save sets only bit 16 as its wake mark.
- R6: The block pulses `err_o` and leaves all other outputs unchanged in three cases: a wake with a code that has no cause value, a code of 10 or more, or an enabled translation-offset condition with `ail_mode_i` equal to 1 or 2.
- R7: The handler address is the table entry (entry i sits at bits 64i+63:64i) ORed with `vec_prefix_i`. An entry of all ones counts as undefined and raises `err_o`.
- R8: The translation-offset condition holds when bits 5 and 4 of `cur_st_i` are both 1 and the new state does not raise bit 60 from 0 to 1. When the condition holds and `ail_mode_i`=3, the handler address is ORed with 0xC000000000004000 and bits 5 and 4 are set in the new state. In every other case neither is applied.
- R9: On a return, `new_pc_o` equals the saved program counter with bits 1:0 cleared, and `new_st_o` equals the saved status with bit 50 (power-save request) cleared. `ret_done_o` pulses.
- R10: On a return where bit 63 (64-bit mode) of the saved status is 0, bits 63:32 of `new_pc_o` are zero.
- R11: After reset all outputs are zero and the block is in IDLE.
- R12: When `take_i` and `ret_i` are high together, only the take is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Take the exception given by the entry inputs |
| ret_i | input | 1 | Return from exception using the save registers |
| exc_code_i | input | 4 | Exception code |
| cur_st_i | input | 64 | Current machine-state word |
| cur_pc_i | input | 64 | Current program counter |
| emb_model_i | input | 1 | Embedded model: save status without masking |
| psave_i | input | 1 | Core was in power-save when the exception arrived |
| ail_mode_i | input | 2 | Translation-offset mode |
| vec_prefix_i | input | 64 | Vector prefix ORed into the handler address |
| vec_table_i | input | 64*NUM_EXC | Handler vector table, one 64-bit entry per code |
| taken_o | output | 1 | One-cycle pulse: entry state updated |
| ret_done_o | output | 1 | One-cycle pulse: return state updated |
| err_o | output | 1 | One-cycle pulse: request refused |
| chkstop_o | output | 1 | Block is in checkstop |
| save_pc_o | output | 64 | Saved program counter |
| save_st_o | output | 64 | Saved status word |
| new_st_o | output | 64 | New machine-state word |
| new_pc_o | output | 64 | Handler address or return address |

## Verification
Some properties are checked on every cycle. The saved program counter must follow the sampled `cur_pc_i`. Return addresses must be word aligned, must have the power-save request bit cleared, and must be truncated when the return is into 32-bit mode. Checkstop must be sticky and must suppress all activity. The three result pulses must be mutually exclusive. The remaining behaviour can only be shown by the bench scenarios, because it depends on specific values in the tables and the state words. That covers the wake-cause encodings, the redirection to the reset vector, the hypervisor-rise rule that blocks the translation offset, detection of an undefined vector, the embedded no-mask case, and the priority of a take over a return.

// File: rtl/ex_pkg.sv
package ex_pkg;
    localparam int XLEN   = 64;
    localparam int CODE_W = 4;

    localparam int ME_B   = 12;
    localparam int HV_B   = 60;
    localparam int RI_B   = 1;
    localparam int IR_B   = 5;
    localparam int DR_B   = 4;
    localparam int POW_B  = 50;
    localparam int SF_B   = 63;
    localparam int WAKE_B = 16;
    localparam int CAUSE_LSB = 18;
    localparam int CAUSE_W   = 4;

    localparam logic [XLEN-1:0] SAVE_CLR = 64'h0000_0000_783F_0000;
    localparam logic [XLEN-1:0] ALT_OFS  = 64'hC000_0000_0000_4000;

    localparam logic [CODE_W-1:0] EXC_RESET    = 4'd0;
    localparam logic [CODE_W-1:0] EXC_MCHECK   = 4'd1;
    localparam logic [CODE_W-1:0] EXC_EXTERNAL = 4'd2;
    localparam logic [CODE_W-1:0] EXC_DECR     = 4'd3;
    localparam logic [CODE_W-1:0] EXC_DBELL    = 4'd4;
    localparam logic [CODE_W-1:0] EXC_HDBELL   = 4'd5;
    localparam logic [CODE_W-1:0] EXC_HMAINT   = 4'd6;
    localparam logic [CODE_W-1:0] EXC_PROGRAM  = 4'd7;
    localparam logic [CODE_W-1:0] EXC_SYSCALL  = 4'd8;
    localparam logic [CODE_W-1:0] EXC_HDECR    = 4'd9;

    typedef enum logic {
        S_IDLE      = 1'b0,
        S_CHECKSTOP = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/ex_wake_cause.sv
module ex_wake_cause
    import ex_pkg::*;
(
    input  logic [CODE_W-1:0]  code_i,
    input  logic               psave_i,
    output logic [CODE_W-1:0]  eff_code_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               bad_o
);
    always_comb begin
        eff_code_o = code_i;
        cause_o    = '0;
        bad_o      = 1'b0;
        if (psave_i && (code_i != EXC_MCHECK)) begin
            eff_code_o = EXC_RESET;
            unique case (code_i)
                EXC_RESET:    cause_o = 4'h4;
                EXC_EXTERNAL: cause_o = 4'h8;
                EXC_DECR:     cause_o = 4'h6;
                EXC_DBELL:    cause_o = 4'h5;
                EXC_HDBELL:   cause_o = 4'h3;
                EXC_HMAINT:   cause_o = 4'hA;
                default:      bad_o   = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ex_entry_calc.sv
module ex_entry_calc
    import ex_pkg::*;
#(
    parameter int NUM_EXC = 10
) (
    input  logic [XLEN-1:0]         cur_st_i,
    input  logic                    emb_model_i,
    input  logic                    psave_i,
    input  logic [CODE_W-1:0]       eff_code_i,
    input  logic [CAUSE_W-1:0]      cause_i,
    input  logic                    wake_bad_i,
    input  logic [1:0]              ail_mode_i,
    input  logic [XLEN-1:0]         vec_prefix_i,
    input  logic [NUM_EXC*XLEN-1:0] vec_table_i,
    output logic [XLEN-1:0]         save_st_o,
    output logic [XLEN-1:0]         new_st_o,
    output logic [XLEN-1:0]         handler_o,
    output logic                    err_o,
    output logic                    chk_o
);
    logic [XLEN-1:0] vec_arr [NUM_EXC];

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_split
        assign vec_arr[g] = vec_table_i[g*XLEN +: XLEN];
    end

    logic [XLEN-1:0] entry;
    logic            undef, hv_rise, alt_ok, alt_bad;

    always_comb begin
        save_st_o = emb_model_i ? cur_st_i : (cur_st_i & ~SAVE_CLR);
        if (psave_i) begin
            save_st_o[WAKE_B] = 1'b1;
            save_st_o[CAUSE_LSB +: CAUSE_W] = save_st_o[CAUSE_LSB +: CAUSE_W] | cause_i;
        end

        new_st_o = '0;
        new_st_o[ME_B] = cur_st_i[ME_B];
        new_st_o[HV_B] = cur_st_i[HV_B];
        unique case (eff_code_i)
            EXC_MCHECK: begin
                new_st_o[HV_B] = 1'b1;
                new_st_o[ME_B] = 1'b0;
            end
            EXC_HDECR, EXC_HDBELL, EXC_HMAINT: begin
                new_st_o[HV_B] = 1'b1;
                new_st_o[RI_B] = cur_st_i[RI_B];
            end
            EXC_RESET: begin
                new_st_o[HV_B] = 1'b1;
                if (psave_i) new_st_o[ME_B] = 1'b1;
            end
            default: ;
        endcase

        chk_o = (eff_code_i == EXC_MCHECK) && !cur_st_i[ME_B];

        if (int'(eff_code_i) < NUM_EXC) entry = vec_arr[eff_code_i];
        else                            entry = '1;
        undef = (entry == '1);

        hv_rise   = new_st_o[HV_B] && !cur_st_i[HV_B];
        alt_ok    = save_st_o[IR_B] && save_st_o[DR_B] && !hv_rise;
        handler_o = entry | vec_prefix_i;
        alt_bad   = 1'b0;
        if (alt_ok) begin
            unique case (ail_mode_i)
                2'd3: begin
                    handler_o      = handler_o | ALT_OFS;
                    new_st_o[IR_B] = 1'b1;
                    new_st_o[DR_B] = 1'b1;
                end
                2'd0:    ;
                default: alt_bad = 1'b1;
            endcase
        end

        err_o = wake_bad_i || undef || alt_bad;
    end
endmodule

// File: rtl/ex_return_calc.sv
module ex_return_calc
    import ex_pkg::*;
(
    input  logic [XLEN-1:0] sv_pc_i,
    input  logic [XLEN-1:0] sv_st_i,
    output logic [XLEN-1:0] ret_pc_o,
    output logic [XLEN-1:0] ret_st_o
);
    always_comb begin
        ret_st_o        = sv_st_i;
        ret_st_o[POW_B] = 1'b0;
        ret_pc_o        = {sv_pc_i[XLEN-1:2], 2'b00};
        if (!ret_st_o[SF_B]) ret_pc_o[XLEN-1:32] = '0;
    end
endmodule

// File: rtl/ex_entry_gen.sv
module ex_entry_gen
    import ex_pkg::*;
#(
    parameter int NUM_EXC = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_i,
    input  logic                    ret_i,
    input  logic [3:0]              exc_code_i,
    input  logic [63:0]             cur_st_i,
    input  logic [63:0]             cur_pc_i,
    input  logic                    emb_model_i,
    input  logic                    psave_i,
    input  logic [1:0]              ail_mode_i,
    input  logic [63:0]             vec_prefix_i,
    input  logic [NUM_EXC*64-1:0]   vec_table_i,
    output logic                    taken_o,
    output logic                    ret_done_o,
    output logic                    err_o,
    output logic                    chkstop_o,
    output logic [63:0]             save_pc_o,
    output logic [63:0]             save_st_o,
    output logic [63:0]             new_st_o,
    output logic [63:0]             new_pc_o
);
    ctl_state_e state_q, state_d;

    logic [CODE_W-1:0]  eff_code;
    logic [CAUSE_W-1:0] cause;
    logic               wake_bad;
    logic [XLEN-1:0]    c_sst, c_nst, c_hnd, r_pc, r_st;
    logic               c_err, c_chk;

    ex_wake_cause u_wake (
        .code_i     (exc_code_i),
        .psave_i    (psave_i),
        .eff_code_o (eff_code),
        .cause_o    (cause),
        .bad_o      (wake_bad)
    );

    ex_entry_calc #(.NUM_EXC(NUM_EXC)) u_calc (
        .cur_st_i     (cur_st_i),
        .emb_model_i  (emb_model_i),
        .psave_i      (psave_i),
        .eff_code_i   (eff_code),
        .cause_i      (cause),
        .wake_bad_i   (wake_bad),
        .ail_mode_i   (ail_mode_i),
        .vec_prefix_i (vec_prefix_i),
        .vec_table_i  (vec_table_i),
        .save_st_o    (c_sst),
        .new_st_o     (c_nst),
        .handler_o    (c_hnd),
        .err_o        (c_err),
        .chk_o        (c_chk)
    );

    ex_return_calc u_ret (
        .sv_pc_i  (save_pc_o),
        .sv_st_i  (save_st_o),
        .ret_pc_o (r_pc),
        .ret_st_o (r_st)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (take_i && c_chk) state_d = S_CHECKSTOP;
            S_CHECKSTOP: state_d = S_CHECKSTOP;
            default:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o    <= 1'b0;
            ret_done_o <= 1'b0;
            err_o      <= 1'b0;
            save_pc_o  <= '0;
            save_st_o  <= '0;
            new_st_o   <= '0;
            new_pc_o   <= '0;
        end else begin
            taken_o    <= 1'b0;
            ret_done_o <= 1'b0;
            err_o      <= 1'b0;
            if (state_q == S_IDLE) begin
                if (take_i) begin
                    if (c_chk) begin
                        // checkstop entry: no architectural update
                    end else if (c_err) begin
                        err_o <= 1'b1;
                    end else begin
                        taken_o   <= 1'b1;
                        save_pc_o <= cur_pc_i;
                        save_st_o <= c_sst;
                        new_st_o  <= c_nst;
                        new_pc_o  <= c_hnd;
                    end
                end else if (ret_i) begin
                    ret_done_o <= 1'b1;
                    new_pc_o   <= r_pc;
                    new_st_o   <= r_st;
                end
            end
        end
    end

    assign chkstop_o = (state_q == S_CHECKSTOP);
endmodule

// File: rtl/ex_entry_chk.sv
module ex_entry_chk
    import ex_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] cur_pc_i,
    input logic        taken_o,
    input logic        ret_done_o,
    input logic        err_o,
    input logic        chkstop_o,
    input logic [63:0] save_pc_o,
    input logic [63:0] new_pc_o,
    input logic [63:0] new_st_o
);
    // R1
    save_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> save_pc_o == $past(cur_pc_i));
    // R3
    chkstop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chkstop_o |=> chkstop_o);
    // R3
    chkstop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chkstop_o) |-> !taken_o && !ret_done_o && !err_o);
    // R9
    ret_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done_o |-> new_pc_o[1:0] == 2'b00);
    // R9
    ret_pow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done_o |-> !new_st_o[POW_B]);
    // R10
    ret_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done_o && !new_st_o[SF_B]) |-> new_pc_o[63:32] == 32'h0);
    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken_o, ret_done_o, err_o}));
endmodule

bind ex_entry_gen ex_entry_chk u_chk (.*);

// File: tb/sim_ex_entry_gen.sv
module sim_ex_entry_gen;
    localparam int NE = 10;
    localparam logic [63:0] ONES = '1;

    logic clk = 0, rst_n = 0, take = 0, ret = 0, emb = 0, psave = 0;
    logic [3:0]  code = 0;
    logic [63:0] cst = 0, cpc = 0, pfx = 0;
    logic [1:0]  ail = 0;
    logic [NE*64-1:0] tbl = 0;
    logic taken, retd, err, chk;
    logic [63:0] spc, sst, nst, npc;

    always #5 clk = ~clk;

    ex_entry_gen #(.NUM_EXC(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .take_i(take), .ret_i(ret), .exc_code_i(code),
        .cur_st_i(cst), .cur_pc_i(cpc), .emb_model_i(emb), .psave_i(psave),
        .ail_mode_i(ail), .vec_prefix_i(pfx), .vec_table_i(tbl),
        .taken_o(taken), .ret_done_o(retd), .err_o(err), .chkstop_o(chk),
        .save_pc_o(spc), .save_st_o(sst), .new_st_o(nst), .new_pc_o(npc));

    int errors = 0, checks = 0, cycles = 0;
    string cur_req = "R11";
    bit done = 0;

    // reference model state
    logic e_taken = 0, e_ret = 0, e_err = 0, m_stop = 0;
    logic [63:0] e_spc = 0, e_sst = 0, e_nst = 0, e_npc = 0;

    always @(posedge clk) begin
        logic [63:0] s, n, v;
        int tgt;
        bit wbad, bad;
        bit [3:0] wc;
        if (!rst_n) begin
            {e_taken, e_ret, e_err, m_stop} = 0;
            {e_spc, e_sst, e_nst, e_npc} = 0;
        end else begin
            e_taken = 0; e_ret = 0; e_err = 0;
            if (m_stop) begin
            end else if (take) begin
                tgt = int'(code); wc = 0; wbad = 0;
                if (psave && code != 4'd1) begin
                    tgt = 0;
                    case (code)
                        4'd0: wc = 4'h4; 4'd2: wc = 4'h8; 4'd3: wc = 4'h6;
                        4'd4: wc = 4'h5; 4'd5: wc = 4'h3; 4'd6: wc = 4'hA;
                        default: wbad = 1;
                    endcase
                end
                s = emb ? cst : (cst & ~64'h783F0000);
                if (psave) s = s | (64'd1 << 16) | (64'(wc) << 18);
                n = cst & ((64'd1 << 12) | (64'd1 << 60));
                if (tgt == 1) n = (n | (64'd1 << 60)) & ~(64'd1 << 12);
                if (tgt == 5 || tgt == 6 || tgt == 9) n = n | (64'd1 << 60) | (cst & 64'd2);
                if (tgt == 0) begin
                    n = n | (64'd1 << 60);
                    if (psave) n = n | (64'd1 << 12);
                end
                v = (tgt < NE) ? tbl[tgt*64 +: 64] : ONES;
                bad = (v == ONES) || wbad;
                v = v | pfx;
                if (cst[5] && cst[4] && !(n[60] && !cst[60])) begin
                    if (ail == 2'd3) begin
                        v = v | 64'hC000_0000_0000_4000;
                        n = n | 64'h30;
                    end else if (ail != 2'd0) bad = 1;
                end
                if (tgt == 1 && !cst[12]) m_stop = 1;
                else if (bad) e_err = 1;
                else begin
                    e_taken = 1; e_spc = cpc; e_sst = s; e_nst = n; e_npc = v;
                end
            end else if (ret) begin
                e_ret = 1;
                e_nst = e_sst & ~(64'd1 << 50);
                e_npc = e_spc & ~64'd3;
                if (!e_sst[63]) e_npc[63:32] = 0;
            end
        end
    end

    task automatic cmp(string nm, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, nm, act, exp);
        end
    endtask

    always @(negedge clk) if (!done) begin
        cmp("taken", 64'(taken), 64'(e_taken));
        cmp("ret_done", 64'(retd), 64'(e_ret));
        cmp("err", 64'(err), 64'(e_err));
        cmp("chkstop", 64'(chk), 64'(m_stop));
        cmp("save_pc", spc, e_spc);
        cmp("save_st", sst, e_sst);
        cmp("new_st", nst, e_nst);
        cmp("new_pc", npc, e_npc);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic go(string req, bit t, bit r, logic [3:0] c, logic [63:0] st, logic [63:0] pc);
        @(negedge clk);
        cur_req = req; take = t; ret = r; code = c; cst = st; cpc = pc;
        @(negedge clk);
        take = 0; ret = 0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) tbl[i*64 +: 64] = 64'h100 * (i + 1) + 64'h20;
        pfx = 64'h0000_0000_0F00_0000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1 R2: ordinary external exception, masked save
        go("R1", 1, 0, 4'd2, 64'h9000_1234_7FFF_F00F, 64'h0000_0040_0000_1003);
        go("R2", 1, 0, 4'd7, 64'h0000_0000_0000_1000, 64'h1000);
        emb = 1;
        go("R1", 1, 0, 4'd8, 64'hFFFF_0000_783F_0001, 64'h2000);
        emb = 0;
        // R4 hypervisor class
        go("R4", 1, 0, 4'd9, 64'h0000_0000_0000_1003, 64'h3000);
        go("R4", 1, 0, 4'd6, 64'h1000_0000_0000_0000, 64'h3004);
        // R5 wake handling
        psave = 1;
        go("R5", 1, 0, 4'd3, 64'h0000_0000_0000_0000, 64'h4000);
        go("R5", 1, 0, 4'd0, 64'h0000_0000_0000_0800, 64'h4004);
        go("R5", 1, 0, 4'd5, 64'h0000_0000_0000_0000, 64'h4008);
        go("R5", 1, 0, 4'd1, 64'h0000_0000_0000_1000, 64'h400C);
        // R6 unsupported wake cause
        go("R6", 1, 0, 4'd9, 64'h0000_0000_0000_0000, 64'h4010);
        psave = 0;
        go("R6", 1, 0, 4'd12, 64'h0, 64'h4014);
        // R7 undefined vector
        tbl[7*64 +: 64] = ONES;
        go("R7", 1, 0, 4'd7, 64'h0, 64'h5000);
        tbl[7*64 +: 64] = 64'h820;
        go("R7", 1, 0, 4'd7, 64'h0, 64'h5004);
        // R8 translation offset
        ail = 2'd3;
        go("R8", 1, 0, 4'd3, 64'h0000_0000_0000_0030, 64'h6000);
        go("R8", 1, 0, 4'd9, 64'h0000_0000_0000_0030, 64'h6004);
        go("R8", 1, 0, 4'd9, 64'h1000_0000_0000_0030, 64'h6008);
        go("R8", 1, 0, 4'd2, 64'h0000_0000_0000_0020, 64'h600C);
        ail = 2'd1;
        go("R6", 1, 0, 4'd2, 64'h0000_0000_0000_0030, 64'h6010);
        go("R8", 1, 0, 4'd2, 64'h0000_0000_0000_0010, 64'h6014);
        ail = 2'd0;
        // R9 return in 64-bit mode with power-save request set
        go("R9", 1, 0, 4'd2, 64'h8004_0000_0000_0000, 64'hABCD_0000_1234_5677);
        go("R9", 0, 1, 4'd0, 64'h0, 64'h0);
        // R10 return into 32-bit mode
        go("R10", 1, 0, 4'd3, 64'h0004_0000_0000_1000, 64'hFFFF_FFFF_8765_4323);
        go("R10", 0, 1, 4'd0, 64'h0, 64'h0);
        // R12 take wins over return
        go("R12", 1, 1, 4'd4, 64'h0, 64'h7000);
        // R3 machine check enabled, then disabled -> checkstop
        go("R3", 1, 0, 4'd1, 64'h0000_0000_0000_1000, 64'h8000);
        go("R3", 1, 0, 4'd1, 64'h0000_0000_0000_0000, 64'h8004);
        go("R3", 1, 0, 4'd2, 64'h0, 64'h8008);
        go("R3", 0, 1, 4'd0, 64'h0, 64'h0);
        // R11 reset clears everything
        @(negedge clk); cur_req = "R11"; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule